// File: doc/BRIEF.md
# Direct-Mapped Data Translation Buffer

This block keeps a small table of virtual-to-physical page mappings for data accesses. Each page is 8 KB. The CPU raises a lookup enable and presents a 32-bit virtual address. One clock later the block returns four outputs, qualified by a done flag:

- a hit flag;
- the 19-bit physical page number;
- four access-permission bits (read and write, for user and supervisor mode);
- a cache-inhibit bit.

Permission checking, exception tagging, page-offset concatenation and bus gating are left to the logic around the block.

Software fills and inspects the table through a register port. The port has a select, a write strobe, an address, write data and read data. Each entry appears as two 32-bit words: a tag word holding the virtual page and a valid flag, and a mapping word holding the physical page, the permissions and the cache-inhibit bit. Only the bits the lookup needs are stored. The entry index is implied by the entry's position, so it is rebuilt from that position on readback.

Top module: `dtlb_dm`

## Requirements
- R1: There are 64 entries. Entry i's tag word is at register address 0x0A00+i and its mapping word is at 0x0B00+i. Writes to any other address, including 0x0A40..0x0AFF and 0x0B40..0x0BFF, change no entry, and reads of any other address return zero.
- R2: In a tag-word write, bits 31:19 give the stored tag and bit 0 gives the valid flag. Reading the word back returns the tag in bits 31:19, the entry index in bits 18:13, the valid flag in bit 0 and zero in every other bit.
- R3: In a mapping-word write, bits 31:13 give the physical page, bit 9 the supervisor write enable, bit 8 the supervisor read enable, bit 7 the user write enable, bit 6 the user read enable and bit 1 the cache-inhibit bit. Reading the word back returns those fields in the same positions and zero in every other bit.
- R4: A lookup uses virtual address bits 18:13 as the entry index. It reports a hit only when the entry is valid and its stored tag equals virtual address bits 31:19.
- R5: `lkp_done` is high in exactly the cycles that follow a clock edge at which `lkp_en` was high. It stays high through back-to-back lookups. `lkp_hit` is never high while `lkp_done` is low.
- R6: On a hit, `lkp_ppn`, the four permission outputs and `lkp_ci` carry the fields of the entry selected by the address sampled at the previous edge.
- R7: Reset (`rst_n` low at a clock edge) clears every valid flag, so every lookup misses until software writes a tag word with bit 0 set.
- R8: A register write takes effect at the clock edge where it is presented. A lookup sampled at that same edge sees the entry's earlier contents.
- R9: `cfg_rdata` is zero whenever `cfg_sel` is low or `cfg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_en | input | 1 | Lookup request for this cycle |
| lkp_vaddr | input | 32 | Virtual data address |
| lkp_hit | output | 1 | Valid entry with matching tag |
| lkp_ppn | output | 19 | Physical page number (physical address bits 31:13) |
| lkp_rd_user | output | 1 | User-mode read allowed |
| lkp_wr_user | output | 1 | User-mode write allowed |
| lkp_rd_sup | output | 1 | Supervisor-mode read allowed |
| lkp_wr_sup | output | 1 | Supervisor-mode write allowed |
| lkp_ci | output | 1 | Cache-inhibit for the page |
| lkp_done | output | 1 | Lookup result is valid this cycle |
| cfg_sel | input | 1 | Register port select |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 32 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |

## Verification
The hardest case to reach is a register write and a lookup that hit the same entry at the same clock edge, because the answer depends on which of them the storage honours first. The bench drives both in one cycle: it rewrites the tag of a valid entry while looking up that entry's old tag. It expects a hit with the old mapping, and then a miss on the following lookup. It also retires entries through a tag-word write with the valid bit clear. Finally it sends writes to the unused upper addresses of each window, whose low six bits alias real entries, and reads the aliased entries back to show they are unchanged.

// File: rtl/dtlb_pkg.sv
// Package: register windows and bit positions shared by the translation buffer.
// Assumes a 32-bit register data path and 8 KB pages.
package dtlb_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned PAGE_W    = 13;
    localparam logic [23:0] TAGW_WIN  = 24'h00000A;
    localparam logic [23:0] MAPW_WIN  = 24'h00000B;
    localparam int unsigned BIT_VALID = 0;
    localparam int unsigned BIT_CI    = 1;
    localparam int unsigned BIT_RU    = 6;
    localparam int unsigned BIT_WU    = 7;
    localparam int unsigned BIT_RS    = 8;
    localparam int unsigned BIT_WS    = 9;

    typedef struct packed {
        logic wr_sup;
        logic rd_sup;
        logic wr_user;
        logic rd_user;
    } perm_t;
endpackage

// File: rtl/dtlb_cfg_dec.sv
// Register-port decoder: sorts an access into the tag-word window or the
// mapping-word window and extracts the entry index.
// Assumes ENTRIES <= 256, so that each window fits in one 256-word block.
module dtlb_cfg_dec #(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             cfg_sel,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_addr,
    output logic             tag_wr,
    output logic             map_wr,
    output logic             tag_rd,
    output logic             map_rd,
    output logic [IDX_W-1:0] idx
);
    import dtlb_pkg::*;

    logic [8:0] off_ext;
    logic       in_rng;
    logic       in_tag;
    logic       in_map;

    // Decode which window the address falls into and whether its offset is populated.
    always_comb begin
        off_ext = {1'b0, cfg_addr[7:0]};
        in_rng  = off_ext < 9'(ENTRIES);
        in_tag  = (cfg_addr[31:8] == TAGW_WIN) && in_rng;
        in_map  = (cfg_addr[31:8] == MAPW_WIN) && in_rng;
        tag_wr  = cfg_sel && cfg_wr && in_tag;
        map_wr  = cfg_sel && cfg_wr && in_map;
        tag_rd  = cfg_sel && !cfg_wr && in_tag;
        map_rd  = cfg_sel && !cfg_wr && in_map;
        idx     = cfg_addr[IDX_W-1:0];
    end

    // R1: the two windows never decode at once.
    always_comb begin
        a_r1_one_window: assert (!((tag_wr || tag_rd) && (map_wr || map_rd)));
    end
endmodule

// File: rtl/dtlb_entry_store.sv
// Entry storage: valid flags (reset), tags, physical pages, permissions and
// cache-inhibit bits. It has a synchronous lookup read port and a combinational
// register readback port.
// Assumes write-before-read is not wanted: a lookup at the edge of a write sees
// the old data.
module dtlb_entry_store #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned TAG_W   = 13,
    parameter int unsigned PPN_W   = 19,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tag_wr,
    input  logic               map_wr,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic               wr_valid,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  dtlb_pkg::perm_t    wr_perm,
    input  logic               wr_ci,
    input  logic               lkp_en,
    input  logic [IDX_W-1:0]   lkp_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [PPN_W-1:0]   rd_ppn,
    output dtlb_pkg::perm_t    rd_perm,
    output logic               rd_ci,
    output logic               rb_valid,
    output logic [TAG_W-1:0]   rb_tag,
    output logic [PPN_W-1:0]   rb_ppn,
    output dtlb_pkg::perm_t    rb_perm,
    output logic               rb_ci
);
    import dtlb_pkg::*;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_mem  [ENTRIES];
    logic [PPN_W-1:0]   ppn_mem  [ENTRIES];
    perm_t              perm_mem [ENTRIES];
    logic [ENTRIES-1:0] ci_mem;

    // Valid flags: cleared by reset, set or cleared by tag-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (tag_wr)
            valid_q[wr_idx] <= wr_valid;
    end

    // Tag storage: written by tag-word writes.
    always_ff @(posedge clk) begin
        if (tag_wr)
            tag_mem[wr_idx] <= wr_tag;
    end

    // Mapping storage: page, permissions and cache-inhibit, written together.
    always_ff @(posedge clk) begin
        if (map_wr) begin
            ppn_mem[wr_idx]  <= wr_ppn;
            perm_mem[wr_idx] <= wr_perm;
            ci_mem[wr_idx]   <= wr_ci;
        end
    end

    // Lookup read: capture the selected entry at the edge where a lookup is requested.
    always_ff @(posedge clk) begin
        if (lkp_en) begin
            rd_valid <= valid_q[lkp_idx];
            rd_tag   <= tag_mem[lkp_idx];
            rd_ppn   <= ppn_mem[lkp_idx];
            rd_perm  <= perm_mem[lkp_idx];
            rd_ci    <= ci_mem[lkp_idx];
        end
    end

    // Readback: present the entry addressed by the register port.
    always_comb begin
        rb_valid = valid_q[wr_idx];
        rb_tag   = tag_mem[wr_idx];
        rb_ppn   = ppn_mem[wr_idx];
        rb_perm  = perm_mem[wr_idx];
        rb_ci    = ci_mem[wr_idx];
    end

    // R2: a tag-word write with bit 0 set leaves that entry valid.
    a_r2_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_wr && wr_valid) |=> valid_q[$past(wr_idx)]);

    // R8: a lookup at the edge of a tag write to the same entry returns the old flag.
    a_r8_old_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_en && tag_wr && (lkp_idx == wr_idx)) |=> (rd_valid == $past(valid_q[lkp_idx])));
endmodule

// File: rtl/dtlb_match.sv
// Lookup qualifier: registers the virtual tag and the request, then compares
// the tag with the entry captured by the store.
// Assumes the store captures its read data on the same edge that enables this.
module dtlb_match #(
    parameter int unsigned TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lkp_en,
    input  logic [TAG_W-1:0] va_tag,
    input  logic             rd_valid,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             done,
    output logic             hit
);
    logic             done_q;
    logic [TAG_W-1:0] tag_q;

    // Result-valid flag: one cycle behind the request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= lkp_en;
    end

    // Capture the virtual tag alongside the entry read.
    always_ff @(posedge clk) begin
        if (lkp_en)
            tag_q <= va_tag;
    end

    // Hit when the result is valid, the entry is valid and the tags agree.
    always_comb begin
        done = done_q;
        hit  = done_q && rd_valid && (rd_tag == tag_q);
    end
endmodule

// File: rtl/dtlb_dm.sv
// Top level: a direct-mapped data translation buffer with a register port.
// Lookup latency is one clock. The register port reads combinationally and
// writes at the clock edge.
// Assumes a 32-bit virtual address and 8 KB pages.
module dtlb_dm #(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned PPN_W  = dtlb_pkg::WORD_W - dtlb_pkg::PAGE_W,
    localparam int unsigned TAG_W  = PPN_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lkp_en,
    input  logic [31:0]      lkp_vaddr,
    output logic             lkp_hit,
    output logic [PPN_W-1:0] lkp_ppn,
    output logic             lkp_rd_user,
    output logic             lkp_wr_user,
    output logic             lkp_rd_sup,
    output logic             lkp_wr_sup,
    output logic             lkp_ci,
    output logic             lkp_done,
    input  logic             cfg_sel,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata
);
    import dtlb_pkg::*;

    logic             tag_wr, map_wr, tag_rd, map_rd;
    logic [IDX_W-1:0] cfg_idx;
    perm_t            wr_perm, rd_perm, rb_perm;
    logic             rd_valid, rd_ci, rb_valid, rb_ci;
    logic [TAG_W-1:0] rd_tag, rb_tag;
    logic [PPN_W-1:0] rd_ppn, rb_ppn;
    logic [31:0]      tag_word, map_word;

    dtlb_cfg_dec #(.ENTRIES(ENTRIES)) u_dec (
        .cfg_sel (cfg_sel),
        .cfg_wr  (cfg_wr),
        .cfg_addr(cfg_addr),
        .tag_wr  (tag_wr),
        .map_wr  (map_wr),
        .tag_rd  (tag_rd),
        .map_rd  (map_rd),
        .idx     (cfg_idx)
    );

    // Unpack the permission field of a mapping-word write.
    always_comb begin
        wr_perm.wr_sup  = cfg_wdata[BIT_WS];
        wr_perm.rd_sup  = cfg_wdata[BIT_RS];
        wr_perm.wr_user = cfg_wdata[BIT_WU];
        wr_perm.rd_user = cfg_wdata[BIT_RU];
    end

    dtlb_entry_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .tag_wr  (tag_wr),
        .map_wr  (map_wr),
        .wr_idx  (cfg_idx),
        .wr_tag  (cfg_wdata[WORD_W-1 -: TAG_W]),
        .wr_valid(cfg_wdata[BIT_VALID]),
        .wr_ppn  (cfg_wdata[WORD_W-1 -: PPN_W]),
        .wr_perm (wr_perm),
        .wr_ci   (cfg_wdata[BIT_CI]),
        .lkp_en  (lkp_en),
        .lkp_idx (lkp_vaddr[PAGE_W +: IDX_W]),
        .rd_valid(rd_valid),
        .rd_tag  (rd_tag),
        .rd_ppn  (rd_ppn),
        .rd_perm (rd_perm),
        .rd_ci   (rd_ci),
        .rb_valid(rb_valid),
        .rb_tag  (rb_tag),
        .rb_ppn  (rb_ppn),
        .rb_perm (rb_perm),
        .rb_ci   (rb_ci)
    );

    dtlb_match #(.TAG_W(TAG_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .lkp_en  (lkp_en),
        .va_tag  (lkp_vaddr[WORD_W-1 -: TAG_W]),
        .rd_valid(rd_valid),
        .rd_tag  (rd_tag),
        .done    (lkp_done),
        .hit     (lkp_hit)
    );

    // Drive the lookup data outputs from the captured entry.
    always_comb begin
        lkp_ppn     = rd_ppn;
        lkp_rd_user = rd_perm.rd_user;
        lkp_wr_user = rd_perm.wr_user;
        lkp_rd_sup  = rd_perm.rd_sup;
        lkp_wr_sup  = rd_perm.wr_sup;
        lkp_ci      = rd_ci;
    end

    // Assemble the two readback word formats, leaving unused bits zero.
    always_comb begin
        tag_word                       = '0;
        tag_word[WORD_W-1 -: TAG_W]    = rb_tag;
        tag_word[PAGE_W +: IDX_W]      = cfg_idx;
        tag_word[BIT_VALID]            = rb_valid;
        map_word                       = '0;
        map_word[WORD_W-1 -: PPN_W]    = rb_ppn;
        map_word[BIT_WS]               = rb_perm.wr_sup;
        map_word[BIT_RS]               = rb_perm.rd_sup;
        map_word[BIT_WU]               = rb_perm.wr_user;
        map_word[BIT_RU]               = rb_perm.rd_user;
        map_word[BIT_CI]               = rb_ci;
    end

    // Select the readback word for the decoded window, zero otherwise.
    always_comb begin
        if (tag_rd)
            cfg_rdata = tag_word;
        else if (map_rd)
            cfg_rdata = map_word;
        else
            cfg_rdata = '0;
    end

    // R5: a hit is only reported with a valid result.
    a_r5_hit_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_hit |-> lkp_done);

    // R5: a result follows a request one clock later.
    a_r5_done_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_en |=> lkp_done);

    // R7: no hit in the first cycle after reset.
    a_r7_no_hit_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !lkp_hit);

    // R3: unused readback positions stay zero.
    a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[5:2] == 4'h0) && (cfg_rdata[12:10] == 3'h0));

    // R9: the read bus is quiet while the port is not selected.
    a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel |-> (cfg_rdata == 32'h0));
endmodule

// File: tb/dtlb_dm_tb.sv
`timescale 1ns/1ps
module dtlb_dm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_en = 1'b0;
    logic [31:0] lkp_vaddr = '0;
    logic        lkp_hit, lkp_rd_user, lkp_wr_user, lkp_rd_sup, lkp_wr_sup, lkp_ci, lkp_done;
    logic [18:0] lkp_ppn;
    logic        cfg_sel = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic        hit;
        logic [18:0] ppn;
        logic [3:0]  perm;
        logic        ci;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    // Bench model of the table; perm packed as {ws, rs, wu, ru}.
    logic [12:0] m_tag  [64];
    logic        m_val  [64];
    logic [18:0] m_ppn  [64];
    logic [3:0]  m_perm [64];
    logic        m_ci   [64];

    always #4 clk = ~clk;

    dtlb_dm u_dut (
        .clk(clk), .rst_n(rst_n), .lkp_en(lkp_en), .lkp_vaddr(lkp_vaddr),
        .lkp_hit(lkp_hit), .lkp_ppn(lkp_ppn), .lkp_rd_user(lkp_rd_user),
        .lkp_wr_user(lkp_wr_user), .lkp_rd_sup(lkp_rd_sup), .lkp_wr_sup(lkp_wr_sup),
        .lkp_ci(lkp_ci), .lkp_done(lkp_done), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] tag_word(input int i, input logic [12:0] t, input logic v);
        return {t, 6'(i), 12'h0, v};
    endfunction

    function automatic logic [31:0] map_word(input logic [18:0] p, input logic [3:0] pm, input logic c);
        return {p, 3'b0, pm, 4'b0, c, 1'b0};
    endfunction

    task automatic model_write(input logic [31:0] a, input logic [31:0] d);
        int i;
        i = int'(a[7:0]);
        if (i < 64 && a[31:8] == 24'h00000A) begin
            m_tag[i] = d[31:19];
            m_val[i] = d[0];
        end else if (i < 64 && a[31:8] == 24'h00000B) begin
            m_ppn[i]  = d[31:13];
            m_perm[i] = d[9:6];
            m_ci[i]   = d[1];
        end
    endtask

    function automatic exp_t predict(input logic [31:0] va, input string req);
        exp_t e;
        int i;
        i = int'(va[18:13]);
        e.hit  = m_val[i] && (m_tag[i] == va[31:19]);
        e.ppn  = m_ppn[i];
        e.perm = m_perm[i];
        e.ci   = m_ci[i];
        e.req  = req;
        return e;
    endfunction

    task automatic reg_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1;
        model_write(a, d);
        cfg_sel = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic reg_read_chk(input logic [31:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b0; cfg_addr = a;
        #1;
        chk(cfg_rdata === exp, req, cfg_rdata, exp);
        cfg_sel = 1'b0;
    endtask

    // Driver: present a lookup and push its expected result.
    task automatic lookup(input logic [31:0] va, input string req);
        @(negedge clk);
        lkp_en = 1'b1; lkp_vaddr = va;
        sb_q.push_back(predict(va, req));
        @(posedge clk);
        #1;
        lkp_en = 1'b0;
    endtask

    // Lookup and register write at the same edge; the expectation uses the old model.
    task automatic lookup_with_write(input logic [31:0] va, input logic [31:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        lkp_en = 1'b1; lkp_vaddr = va;
        cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        sb_q.push_back(predict(va, req));
        @(posedge clk);
        #1;
        model_write(a, d);
        lkp_en = 1'b0; cfg_sel = 1'b0; cfg_wr = 1'b0;
    endtask

    function automatic logic [31:0] va_of(input logic [12:0] t, input int i, input logic [12:0] off);
        return {t, 6'(i), off};
    endfunction

    // Monitor: pop and compare each lookup result as the design reports it.
    always @(negedge clk) begin
        if (rst_n && lkp_done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R5 unexpected done", 32'(lkp_done), 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(lkp_hit === e.hit, {e.req, " hit"}, 32'(lkp_hit), 32'(e.hit));
                if (e.hit) begin
                    chk(lkp_ppn === e.ppn, "R6 ppn", 32'(lkp_ppn), 32'(e.ppn));
                    chk({lkp_wr_sup, lkp_rd_sup, lkp_wr_user, lkp_rd_user} === e.perm, "R6 perm",
                        32'({lkp_wr_sup, lkp_rd_sup, lkp_wr_user, lkp_rd_user}), 32'(e.perm));
                    chk(lkp_ci === e.ci, "R6 ci", 32'(lkp_ci), 32'(e.ci));
                end
            end
        end
    end

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_val[i] = 1'b0; m_tag[i] = '0; m_ppn[i] = '0; m_perm[i] = '0; m_ci[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R5 R7: reset state
        chk(lkp_done === 1'b0, "R5 done in reset", 32'(lkp_done), 32'h0);
        chk(lkp_hit === 1'b0, "R7 hit in reset", 32'(lkp_hit), 32'h0);
        chk(cfg_rdata === 32'h0, "R9 rdata in reset", cfg_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: everything misses after reset
        lookup(va_of(13'h0000, 0, 13'h0), "R7");
        lookup(va_of(13'h1ABC, 5, 13'h123), "R7");
        lookup(va_of(13'h0001, 63, 13'h1FFF), "R7");

        // Fill three entries
        reg_write(32'h0A05, tag_word(5, 13'h1ABC, 1'b1));
        reg_write(32'h0B05, map_word(19'h12345, 4'b1010, 1'b1));
        reg_write(32'h0A3F, tag_word(63, 13'h0001, 1'b1));
        reg_write(32'h0B3F, map_word(19'h7FFFF, 4'b0101, 1'b0));
        reg_write(32'h0A00, tag_word(0, 13'h1FFF, 1'b1) | 32'h0007_E3FE);
        reg_write(32'h0B00, map_word(19'h00000, 4'b1111, 1'b0) | 32'h0000_1C3D);

        // R2 R3: readback formats (junk bits written to entry 0 must read as zero)
        reg_read_chk(32'h0A05, tag_word(5, 13'h1ABC, 1'b1), "R2 tag word 5");
        reg_read_chk(32'h0B05, map_word(19'h12345, 4'b1010, 1'b1), "R3 map word 5");
        reg_read_chk(32'h0A00, tag_word(0, 13'h1FFF, 1'b1), "R2 tag word 0");
        reg_read_chk(32'h0B00, map_word(19'h00000, 4'b1111, 1'b0), "R3 map word 0");
        reg_read_chk(32'h0A3F, tag_word(63, 13'h0001, 1'b1), "R2 tag word 63");

        // R4 R6: hits, then misses on a wrong tag and an unwritten index
        lookup(va_of(13'h1ABC, 5, 13'h0AAA), "R4");
        lookup(va_of(13'h0001, 63, 13'h0000), "R4");
        lookup(va_of(13'h1FFF, 0, 13'h1FFF), "R4");
        lookup(va_of(13'h1ABD, 5, 13'h0), "R4 wrong tag");
        lookup(va_of(13'h1ABC, 6, 13'h0), "R4 other index");

        // R5: back-to-back burst keeps done high; then done drops
        for (int k = 0; k < 6; k++)
            lookup(va_of((k % 2) ? 13'h0001 : 13'h1ABC, (k % 2) ? 63 : 5, 13'(k)), "R5 burst");
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(lkp_done === 1'b0, "R5 done drops", 32'(lkp_done), 32'h0);
        chk(lkp_hit === 1'b0, "R5 hit without done", 32'(lkp_hit), 32'h0);

        // R8: rewrite entry 63's tag while looking up the old tag
        lookup_with_write(va_of(13'h0001, 63, 13'h0), 32'h0A3F, tag_word(63, 13'h0777, 1'b1), "R8 old view");
        lookup(va_of(13'h0001, 63, 13'h0), "R8 new miss");
        lookup(va_of(13'h0777, 63, 13'h0), "R8 new hit");

        // R2 R7: clearing valid retires the entry
        reg_write(32'h0A05, tag_word(5, 13'h1ABC, 1'b0));
        lookup(va_of(13'h1ABC, 5, 13'h0), "R2 invalidated");

        // R1: out-of-window accesses alias no entry
        reg_write(32'h0A40, tag_word(0, 13'h0123, 1'b0));
        reg_write(32'h0B40, map_word(19'h55555, 4'b0000, 1'b1));
        reg_write(32'h0C00, 32'hFFFF_FFFF);
        reg_read_chk(32'h0A40, 32'h0, "R1 read 0x0A40");
        reg_read_chk(32'h0C00, 32'h0, "R1 read 0x0C00");
        reg_read_chk(32'h0A00, tag_word(0, 13'h1FFF, 1'b1), "R1 entry 0 tag intact");
        reg_read_chk(32'h0B00, map_word(19'h00000, 4'b1111, 1'b0), "R1 entry 0 map intact");
        lookup(va_of(13'h1FFF, 0, 13'h0), "R1 entry 0 still hits");

        // R9: no read data while unselected or writing
        @(negedge clk);
        cfg_sel = 1'b0; cfg_wr = 1'b0; cfg_addr = 32'h0A00;
        #1;
        chk(cfg_rdata === 32'h0, "R9 unselected", cfg_rdata, 32'h0);
        cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = 32'h0C01;
        #1;
        chk(cfg_rdata === 32'h0, "R9 during write", cfg_rdata, 32'h0);
        cfg_sel = 1'b0; cfg_wr = 1'b0;

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R5 all results seen", 32'(sb_q.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule